// File: doc/BRIEF.md
# Period/Duty Compare PWM Generator

This block produces one pulse-width-modulated output from a 16-bit up-counter and two compare values. The period compare sets the cycle length: the counter returns to zero on the clock edge after it equals that value. The duty compare sets the point where the output switches to its active level. Software programs the block through a small write port. A control word starts and stops the count, selects the active polarity and can disable the pin. Two sticky match flags tell software which compare has matched, and software clears each flag by writing 0 to it.

The two ends of the duty range are handled directly. When the duty value equals the period value, both compares match in the same cycle. The duty match wins, so the output stays active and the duty is 100%. When the duty value is above the period value, the duty compare never matches, so the output never goes active and the duty is 0%. Software may change the duty value while the counter runs, and later matches use the new value.

There is no streaming data path. All pins are plain control and status signals with no valid/ready handshake, so the block never applies back-pressure. A write is accepted in every cycle that `wr_en` is high.

Top module: `pwm_dual_cmp`

## Requirements
- R1: Write address 0 is the control word. Bit 0 runs the counter (1 = run), bit 1 is the polarity (0 = active low, 1 = active high), and bit 2 disables the pin (1 = disabled). While the run bit is 1, the counter (`count`) increments by one each cycle. While the run bit is 0, the counter holds its value.
- R2: Write address 1 is the period compare. When the running counter equals it, the counter is 0 in the next cycle.
- R3: Write address 2 is the duty compare. When the running counter equals it, the output is at the active level from the next cycle.
- R4: When the period compare matches and the duty compare does not match in the same cycle, the output goes to the inactive level (the inverse of the polarity bit) in the next cycle.
- R5: When both compares match in the same cycle, the duty match wins and the output stays active. A duty value equal to the period value therefore gives an output that is active for all period+1 cycles.
- R6: When the duty value is greater than the period value, the output is never active (0% duty).
- R7: Flag A (`flag_a`) is set by each period match and flag B (`flag_b`) by each duty match. A write to address 3 clears flag A if data bit 0 is 0 and clears flag B if data bit 1 is 0. A bit written as 1 leaves its flag unchanged.
- R8: A clear of a flag in the same cycle as a new match for that flag loses to the match, so the flag stays set.
- R9: A duty value rewritten while the counter runs governs all later matches.
- R10: While the disable bit is 1, the pin is at the inactive level.
- R11: While the counter is stopped, the output holds its last level.
- R12: After reset, the counter is 0, both flags are 0, the run bit is 0, the polarity is 0 and the pin is at the inactive level (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 period, 2 duty, 3 flag clear |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM pin |
| flag_a | output | 1 | Sticky period-match flag |
| flag_b | output | 1 | Sticky duty-match flag |
| count | output | 16 | Current counter value |

## Verification
A write is captured at the clock edge after it is driven, and the new value acts from the next cycle. A compare match seen at one edge changes the counter, the output level and the flags at the following edge, so each result is due one cycle after the cycle in which its counter value is visible. The bench drives inputs and samples outputs at the falling edge. It measures duty by counting active samples over one full period that starts where `count` reads 0. Before measuring, it waits three periods so that any output level left over from earlier activity has cleared. For the set-against-clear collision, the bench issues the clear in the same falling-edge slot where it sees `count` equal to the period value.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CNT_W = 16;

  typedef enum logic [1:0] {
    ADR_CTL = 2'd0,
    ADR_PER = 2'd1,
    ADR_DUT = 2'd2,
    ADR_STS = 2'd3
  } reg_adr_e;

  localparam int unsigned CTL_RUN = 0;
  localparam int unsigned CTL_POL = 1;
  localparam int unsigned CTL_OFF = 2;
  localparam int unsigned NFLAGS  = 2;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         run,
  output logic         pol,
  output logic         off,
  output logic [W-1:0] per_val,
  output logic [W-1:0] dut_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      pol     <= 1'b0;
      off     <= 1'b0;
      per_val <= '0;
      dut_val <= '0;
    end else if (wr_en) begin
      unique case (reg_adr_e'(wr_addr))
        ADR_CTL: begin
          run <= wr_data[CTL_RUN];
          pol <= wr_data[CTL_POL];
          off <= wr_data[CTL_OFF];
        end
        ADR_PER: per_val <= wr_data;
        ADR_DUT: dut_val <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] per_val,
  input  logic [W-1:0] dut_val,
  output logic [W-1:0] cnt,
  output logic         hit_per,
  output logic         hit_dut
);
  assign hit_per = run && (cnt == per_val);
  assign hit_dut = run && (cnt == dut_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (hit_per) cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_per,
  input  logic hit_dut,
  input  logic pol,
  input  logic off,
  output logic lvl,
  output logic pin
);
  // lvl = 1 means active; the duty match has priority over the period match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lvl <= 1'b0;
    else if (hit_dut) lvl <= 1'b1;
    else if (hit_per) lvl <= 1'b0;
  end

  assign pin = (off || !lvl) ? ~pol : pol;
endmodule

// File: rtl/pwm_flags.sv
module pwm_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr,
  input  logic [N-1:0] keep_bits,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       flags[i] <= 1'b0;
      else if (set_i[i])                flags[i] <= 1'b1;
      else if (clr_wr && !keep_bits[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_dual_cmp.sv
module pwm_dual_cmp
  import pwm_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         pwm_out,
  output logic         flag_a,
  output logic         flag_b,
  output logic [W-1:0] count
);
  logic         run_q, pol_q, off_q, lvl_q;
  logic [W-1:0] per_q, dut_q, cnt_q;
  logic         hit_per, hit_dut;
  logic [NFLAGS-1:0] flg;
  logic         sts_wr;

  pwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(run_q), .pol(pol_q), .off(off_q),
    .per_val(per_q), .dut_val(dut_q)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .per_val(per_q),
    .dut_val(dut_q), .cnt(cnt_q), .hit_per(hit_per), .hit_dut(hit_dut)
  );

  pwm_outstage u_out (
    .clk(clk), .rst_n(rst_n), .hit_per(hit_per), .hit_dut(hit_dut),
    .pol(pol_q), .off(off_q), .lvl(lvl_q), .pin(pwm_out)
  );

  assign sts_wr = wr_en && (reg_adr_e'(wr_addr) == ADR_STS);

  pwm_flags #(.N(NFLAGS)) u_flg (
    .clk(clk), .rst_n(rst_n), .set_i({hit_dut, hit_per}),
    .clr_wr(sts_wr), .keep_bits(wr_data[NFLAGS-1:0]), .flags(flg)
  );

  assign flag_a = flg[0];
  assign flag_b = flg[1];
  assign count  = cnt_q;
endmodule

// File: rtl/pwm_dual_cmp_chk.sv
module pwm_dual_cmp_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_q,
  input logic         pol_q,
  input logic         off_q,
  input logic         lvl_q,
  input logic [W-1:0] per_q,
  input logic [W-1:0] dut_q,
  input logic [W-1:0] count,
  input logic         pwm_out,
  input logic         flag_a,
  input logic         flag_b
);
  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> count == $past(count));
  // R2
  per_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && count == per_q) |=> count == '0);
  // R5
  dut_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && count == dut_q) |=> lvl_q);
  // R4
  per_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && count == per_q && count != dut_q) |=> !lvl_q);
  // R7
  flag_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && count == per_q) |=> flag_a);
  // R7
  flag_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && count == dut_q) |=> flag_b);
  // R10
  pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> pwm_out == ~pol_q);
  // R11
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> lvl_q == $past(lvl_q));
endmodule

bind pwm_dual_cmp pwm_dual_cmp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .pol_q(pol_q), .off_q(off_q),
  .lvl_q(lvl_q), .per_q(per_q), .dut_q(dut_q), .count(count),
  .pwm_out(pwm_out), .flag_a(flag_a), .flag_b(flag_b)
);

// File: tb/pwm_dual_cmp_tb.sv
`timescale 1ns/1ps
module pwm_dual_cmp_tb;
  localparam int W = 16;
  localparam int NV = 6;
  // {period, duty, polarity, expected active cycles per period}
  localparam logic [15:0] VEC [NV][4] = '{
    '{16'd4, 16'd2, 16'd0, 16'd2},
    '{16'd7, 16'd0, 16'd1, 16'd7},
    '{16'd5, 16'd5, 16'd0, 16'd6},
    '{16'd3, 16'd9, 16'd1, 16'd0},
    '{16'd6, 16'd5, 16'd0, 16'd1},
    '{16'd2, 16'd1, 16'd1, 16'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic pwm_out, flag_a, flag_b;
  logic [W-1:0] count;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_dual_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .flag_a(flag_a),
    .flag_b(flag_b), .count(count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_zero();
    while (count != 0) @(negedge clk);
  endtask

  task automatic measure(input int per, input logic pol, output int act);
    act = 0;
    wait_zero();
    for (int k = 0; k <= per; k++) begin
      if (pwm_out == pol) act++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int act;
    int c0;
    logic p0;
    do_reset();
    @(negedge clk);
    // R12 reset state
    chk("R12 pin", pwm_out, 1);
    chk("R12 flag_a", flag_a, 0);
    chk("R12 flag_b", flag_b, 0);
    chk("R12 count", count, 0);
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", count, 0);

    // table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr(2'd1, VEC[v][0]);
      wr(2'd2, VEC[v][1]);
      wr(2'd0, {13'd0, 1'b0, VEC[v][2][0], 1'b1});
      repeat (3 * (VEC[v][0] + 1)) @(negedge clk);
      measure(int'(VEC[v][0]), VEC[v][2][0], act);
      chk($sformatf("R3/R4/R5/R6 vec%0d duty", v), act, int'(VEC[v][3]));
    end

    // R2 count returns to 0 after period value
    do_reset();
    wr(2'd1, 16'd4); wr(2'd2, 16'd2); wr(2'd0, 16'h0001);
    wait_zero();
    while (count != 4) @(negedge clk);
    @(negedge clk);
    chk("R2 wrap", count, 0);

    // R1 / R11 stop holds counter and output
    repeat (2) @(negedge clk);
    wr(2'd0, 16'h0000);
    c0 = count; p0 = pwm_out;
    repeat (4) @(negedge clk);
    chk("R1 stopped count", count, c0);
    chk("R11 stopped pin", pwm_out, p0);

    // R7 flags sticky, cleared per bit by writing 0
    chk("R7 flag_a set", flag_a, 1);
    chk("R7 flag_b set", flag_b, 1);
    wr(2'd3, 16'h0002);
    chk("R7 clear a", flag_a, 0);
    chk("R7 b kept", flag_b, 1);
    wr(2'd3, 16'h0001);
    chk("R7 clear b", flag_b, 0);

    // R8 clear colliding with a period match
    wr(2'd0, 16'h0001);
    repeat (10) @(negedge clk);
    while (count != 4) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 flag_a kept", flag_a, 1);
    chk("R7 flag_b cleared", flag_b, 0);

    // R10 disabled pin stays inactive
    wr(2'd0, 16'h0005);
    act = 0;
    for (int k = 0; k < 10; k++) begin
      if (pwm_out != 1'b1) act++;
      @(negedge clk);
    end
    chk("R10 off pol0", act, 0);
    wr(2'd0, 16'h0007);
    act = 0;
    for (int k = 0; k < 10; k++) begin
      if (pwm_out != 1'b0) act++;
      @(negedge clk);
    end
    chk("R10 off pol1", act, 0);

    // R9 duty rewrite while running
    do_reset();
    wr(2'd1, 16'd9); wr(2'd2, 16'd8); wr(2'd0, 16'h0001);
    repeat (30) @(negedge clk);
    measure(9, 1'b0, act);
    chk("R9 before rewrite", act, 1);
    wait_zero();
    wr(2'd2, 16'd3);
    measure(9, 1'b0, act);
    chk("R9 after rewrite", act, 6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule